// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block is the host side of an enhanced parallel link. A single command from the host logic (read or write, address or data, and a byte for writes) turns into one complete interlocked bus cycle in hardware. The engine drives the direction line and the two strobes (one for address cycles, one for data cycles), controls the output enable of the shared 8-bit data bus, and follows the peripheral's wait line through both halves of the handshake. When the cycle ends it pulses a completion flag and, for reads, presents the captured byte.

The peripheral's wait line comes in through a synchronizer. A new command is taken only while that synchronized line shows the peripheral ready (low). Each half of the handshake has a watchdog. If the peripheral does not answer in time, the engine releases every strobe, turns the bus around and ends the command with an error flag. The data bus has separate input, output and enable pins, so a pad cell or the chip's top level can build the tri-state buffer.

Top module: `epp_host_engine`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, the direction line is high (read/idle), both strobes are high, the bus output enable is low and done and error are low.
- R2: On a write command the direction line goes low and the command byte is driven with the enable high. Then exactly one strobe goes low: the address strobe for an address command, the data strobe for a data command. The two strobes are never low at the same time.
- R3: A strobe stays low until the synchronized wait line is seen high, and it is then released. On the strobe's rising edge the bus carries the command byte, and the strobe that rose matches the command kind.
- R4: On a read command the direction line stays high and the output enable stays low for the whole cycle. The bus value present once wait is seen high is returned on the read data output while done is high.
- R5: For a write, the bus is driven with the command byte and the enable is high for at least one clock before the strobe falls.
- R6: Done is a single-cycle pulse. For a successful cycle it comes only after the wait line has returned low following the strobe release.
- R7: In the cycle where done is high, both strobes are high, the direction line is high and the output enable is low. This gives at least one clock with the bus released after every cycle, reads included.
- R8: The ready output is high only when the engine is idle and the synchronized wait line is low. A request held while wait is high starts no cycle: no strobe falls.
- R9: If wait does not rise within TIMEOUT_CYC clocks of the strobe falling, the strobe is released, the bus is turned around and done pulses together with the error flag.
- R10: If wait does not return low within TIMEOUT_CYC clocks of the strobe release, done pulses together with the error flag. The error flag is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_addr_i | input | 1 | 1 = address cycle, 0 = data cycle |
| cmd_wdata_i | input | 8 | Byte to send on writes |
| cmd_ready_o | output | 1 | Engine idle and peripheral ready; command taken when valid and ready |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done |
| rdata_o | output | 8 | Byte captured by the last read cycle |
| n_write_o | output | 1 | Direction line, low for host-to-peripheral |
| n_astb_o | output | 1 | Address strobe, active low |
| n_dstb_o | output | 1 | Data strobe, active low |
| n_wait_i | input | 1 | Peripheral wait line (low = ready, high = acknowledged) |
| bus_o | output | 8 | Data bus output value |
| bus_oe_o | output | 1 | Data bus output enable |
| bus_i | input | 8 | Data bus input value |

## Verification
A wrong internal state shows up at the pins within one handshake phase. A stuck or wrongly entered phase either leaves a strobe low while wait is already high, which the peripheral model sees as a missing edge, or ends with an error flag within TIMEOUT_CYC clocks. A wrong direction or enable decision shows in the same cycle as an enabled bus during a read, or as a byte latched by the peripheral that differs from the command. A completion reported too early shows on the one done cycle, because the wait line is still high there.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    parameter int unsigned EPP_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RELEASE = 2'd3
    } epp_state_e;

    typedef struct packed {
        epp_state_e          state;
        logic                is_addr;
        logic                is_write;
        logic                n_write;
        logic                n_astb;
        logic                n_dstb;
        logic                oe;
        logic [EPP_DW-1:0]   bus;
        logic [EPP_DW-1:0]   rdata;
        logic                done;
        logic                err;
    } epp_regs_t;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
    parameter int unsigned LIMIT = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !run_i)    cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_host_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic              cmd_write_i,
    input  logic              cmd_addr_i,
    input  logic [EPP_DW-1:0] cmd_wdata_i,
    output logic              cmd_ready_o,
    output logic              done_o,
    output logic              err_o,
    output logic [EPP_DW-1:0] rdata_o,
    output logic              n_write_o,
    output logic              n_astb_o,
    output logic              n_dstb_o,
    input  logic              n_wait_i,
    output logic [EPP_DW-1:0] bus_o,
    output logic              bus_oe_o,
    input  logic [EPP_DW-1:0] bus_i
);
    epp_regs_t r_d, r_q;
    logic      wait_s;
    logic      tmo_exp;
    logic      tmo_run;
    logic      tmo_clr;

    epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (n_wait_i),
        .q_o    (wait_s)
    );

    assign tmo_run = (r_q.state == ST_STROBE) || (r_q.state == ST_RELEASE);
    assign tmo_clr = (r_q.state != r_d.state);

    epp_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tmo_clr),
        .run_i     (tmo_run),
        .expired_o (tmo_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid_i && !wait_s) begin
                    r_d.is_addr  = cmd_addr_i;
                    r_d.is_write = cmd_write_i;
                    r_d.n_write  = !cmd_write_i;
                    r_d.oe       = cmd_write_i;
                    r_d.bus      = cmd_write_i ? cmd_wdata_i : r_q.bus;
                    r_d.state    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                // byte (or released bus) has been stable for one clock
                r_d.n_astb = !r_q.is_addr;
                r_d.n_dstb = r_q.is_addr;
                r_d.state  = ST_STROBE;
            end
            ST_STROBE: begin
                if (wait_s) begin
                    if (!r_q.is_write) r_d.rdata = bus_i;
                    r_d.n_astb = 1'b1;
                    r_d.n_dstb = 1'b1;
                    r_d.state  = ST_RELEASE;
                end else if (tmo_exp) begin
                    r_d.n_astb  = 1'b1;
                    r_d.n_dstb  = 1'b1;
                    r_d.oe      = 1'b0;
                    r_d.n_write = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.err     = 1'b1;
                    r_d.state   = ST_IDLE;
                end
            end
            ST_RELEASE: begin
                if (!wait_s || tmo_exp) begin
                    r_d.oe      = 1'b0;
                    r_d.n_write = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.err     = wait_s;
                    r_d.state   = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.n_write  <= 1'b1;
            r_q.n_astb   <= 1'b1;
            r_q.n_dstb   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready_o = (r_q.state == ST_IDLE) && !wait_s;
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign rdata_o     = r_q.rdata;
    assign n_write_o   = r_q.n_write;
    assign n_astb_o    = r_q.n_astb;
    assign n_dstb_o    = r_q.n_dstb;
    assign bus_o       = r_q.bus;
    assign bus_oe_o    = r_q.oe;
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cmd_ready_o,
    input logic done_o,
    input logic err_o,
    input logic n_write_o,
    input logic n_astb_o,
    input logic n_dstb_o,
    input logic bus_oe_o
);
    // R2
    one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({!n_astb_o, !n_dstb_o}) <= 1);

    // R2
    wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!n_astb_o || !n_dstb_o) && !n_write_o) |-> bus_oe_o);

    // R4
    rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> !n_write_o);

    // R5
    setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($fell(n_astb_o) || $fell(n_dstb_o)) && !n_write_o) |-> $past(bus_oe_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (n_astb_o && n_dstb_o && n_write_o && !bus_oe_o));

    // R8
    ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_ready_o |-> (n_astb_o && n_dstb_o));

    // R10
    err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> done_o);
endmodule

bind epp_host_engine epp_host_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_ready_o (cmd_ready_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .n_write_o   (n_write_o),
    .n_astb_o    (n_astb_o),
    .n_dstb_o    (n_dstb_o),
    .bus_oe_o    (bus_oe_o)
);

// File: tb/epp_host_engine_tb_top.sv
module epp_host_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_addr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       cmd_ready, done, err;
    logic [7:0] rdata, bus_o, bus_i;
    logic       n_write, n_astb, n_dstb, bus_oe, n_wait;

    always #2 clk = ~clk; // 250 MHz

    epp_host_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_ready_o(cmd_ready),
        .done_o(done), .err_o(err), .rdata_o(rdata), .n_write_o(n_write),
        .n_astb_o(n_astb), .n_dstb_o(n_dstb), .n_wait_i(n_wait), .bus_o(bus_o),
        .bus_oe_o(bus_oe), .bus_i(bus_i)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- peripheral model ----------------
    int         dly = 1;
    bit         mute = 0, stick = 0, force_hi = 0;
    logic [7:0] rd_byte = 8'h00;
    logic       pw, pdrv, prev_a, prev_d, lat_addr;
    logic [7:0] lat_data;
    int         pcnt, lat_cnt;
    wire        stb_low = !n_astb || !n_dstb;

    assign n_wait = pw | force_hi;
    assign bus_i  = pdrv ? rd_byte : 8'hFF;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw <= 0; pdrv <= 0; pcnt <= 0; lat_cnt <= 0;
            prev_a <= 1; prev_d <= 1; lat_data <= 0; lat_addr <= 0;
        end else begin
            prev_a <= n_astb; prev_d <= n_dstb;
            if ((n_astb && !prev_a) || (n_dstb && !prev_d)) begin
                lat_data <= bus_o; lat_addr <= !prev_a; lat_cnt <= lat_cnt + 1;
            end
            if (stb_low && !pw) begin
                if (mute) pcnt <= 0;
                else if (pcnt >= dly) begin pw <= 1; pcnt <= 0; if (n_write) pdrv <= 1; end
                else pcnt <= pcnt + 1;
            end else if (!stb_low && pw) begin
                if (stick) pcnt <= 0;
                else if (pcnt >= dly) begin pw <= 0; pdrv <= 0; pcnt <= 0; end
                else pcnt <= pcnt + 1;
            end else pcnt <= 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit rd; bit ad; logic [7:0] data; bit err; } exp_t;
    exp_t q[$];
    int   done_cnt = 0, last_lat = 0;
    logic m_prev_a = 1, m_prev_d = 1, m_prev_oe = 0;
    logic [7:0] m_prev_bus = 0;
    bit   rd_oe_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0) begin
                if (((!n_astb && m_prev_a) || (!n_dstb && m_prev_d)) && !n_write) // R5
                    chk(m_prev_oe && m_prev_bus == q[0].data, "R5 setup", {m_prev_oe, m_prev_bus}, {1'b1, q[0].data});
                if (q[0].rd && (bus_oe || !n_write)) rd_oe_bad = 1;
            end
            if (done) begin
                exp_t e;
                done_cnt++;
                if (q.size() == 0) chk(0, "R6 unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(err == e.err, e.err ? "R9/R10 error flag" : "R6 no error", err, e.err);
                    chk(n_astb && n_dstb && n_write && !bus_oe, "R7 idle at done",
                        {n_astb, n_dstb, n_write, bus_oe}, 4'b1110);
                    if (!e.err) begin
                        chk(!n_wait, "R6 wait low at done", n_wait, 0);
                        if (e.rd) begin
                            chk(rdata == e.data, "R4 read data", rdata, e.data);
                            chk(!rd_oe_bad, "R4 bus released", rd_oe_bad, 0);
                        end else begin
                            chk(lat_cnt == last_lat + 1 && lat_data == e.data, "R3 latched byte",
                                lat_data, e.data);
                            chk(lat_addr == e.ad, "R2 strobe kind", lat_addr, e.ad);
                        end
                    end
                    rd_oe_bad = 0;
                    last_lat  = lat_cnt;
                end
            end
        end
        m_prev_a = n_astb; m_prev_d = n_dstb; m_prev_oe = bus_oe; m_prev_bus = bus_o;
    end

    // ---------------- driver ----------------
    task automatic do_cmd(input bit wr, input bit ad, input logic [7:0] d, input bit e_err);
        exp_t e;
        int   tgt;
        e.rd = !wr; e.ad = ad; e.data = d; e.err = e_err;
        if (!wr) rd_byte = d;
        @(negedge clk);
        q.push_back(e);
        tgt = done_cnt + 1;
        cmd_valid = 1; cmd_write = wr; cmd_addr = ad; cmd_wdata = wr ? d : 8'h00;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (done_cnt < tgt) @(negedge clk);
    endtask

    task automatic run_tests();
        bit bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(n_write && n_astb && n_dstb && !bus_oe && !done && !err, "R1 in reset",
            {n_write, n_astb, n_dstb, bus_oe, done, err}, 6'b111000);
        rst_n = 1;
        @(negedge clk);
        chk(n_write && n_astb && n_dstb && !bus_oe && !done && !err, "R1 after reset",
            {n_write, n_astb, n_dstb, bus_oe, done, err}, 6'b111000);
        // R2 R3 writes
        dly = 1; do_cmd(1, 0, 8'hA5, 0);
        dly = 3; do_cmd(1, 1, 8'h3C, 0);
        do_cmd(1, 0, 8'h00, 0);
        do_cmd(1, 1, 8'hFF, 0);
        // R4 reads
        dly = 2; do_cmd(0, 0, 8'h5A, 0);
        do_cmd(0, 1, 8'hC3, 0);
        // R3 long interlock, no timeout
        dly = 20; do_cmd(0, 0, 8'h96, 0);
        do_cmd(1, 0, 8'h69, 0);
        dly = 1;
        // R8 request held while wait high
        force_hi = 1;
        repeat (4) @(negedge clk);
        cmd_valid = 1; cmd_write = 1; cmd_addr = 0; cmd_wdata = 8'h11;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (cmd_ready || !n_astb || !n_dstb) bad = 1;
        end
        chk(!bad, "R8 no cycle while wait high", bad, 0);
        cmd_valid = 0;
        force_hi = 0;
        do_cmd(1, 0, 8'h11, 0);
        // R9 no answer to strobe
        mute = 1; do_cmd(1, 0, 8'h22, 1);
        mute = 0;
        do_cmd(0, 1, 8'h44, 0);
        // R10 wait never returns low
        stick = 1; do_cmd(1, 1, 8'h33, 1);
        stick = 0;
        repeat (10) @(negedge clk);
        do_cmd(1, 0, 8'h81, 0);
        do_cmd(0, 0, 8'h7E, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog", 1, 0);
            end
        join_any
        disable fork;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule